// File: doc/BRIEF.md
# Cascadable Segment Row Loader

This block is the column side of a dot-matrix display driver. Pixel data arrives on a parallel bus, either four or eight pixels per data strobe. The block fills a row-wide data latch from one of its two ends. Several devices share the bus and form a chain. A device takes data only after an enable token reaches it. It fills exactly one row and then passes the token on with a one-strobe low pulse.

A falling edge of the line pulse copies the whole data latch into a line latch in one step. The same edge re-arms the selection and count logic. Each column of the line latch is then encoded into a 2-bit drive-level code. The code depends on the pixel, the frame polarity and an active-low blanking input.

The data strobe and line pulse are free-running inputs. Each passes through a two-flop synchroniser and a falling-edge detector clocked by the system clock.

Top module: `seg_row_loader`

## Requirements
- R1: After reset the line latch holds all zeros, so with `blank_n`=1 and `frame_pol`=0 every column code is 1, and both chain outputs are high.
- R2: With `nibble_mode`=0, each strobe fall stores the eight bits of `pix_in`, so NCOL/8 strobes fill a row. With `fill_up`=1, bit j of strobe n (n from 0) lands on column 8n+j, counting columns from 0.
- R3: With `nibble_mode`=1, each strobe fall stores `pix_in[3:0]` and `pix_in[7:4]` is ignored. Strobe n bit j lands on the column that is 4n+j positions from the starting end, so a row takes NCOL/4 strobes.
- R4: With `fill_up`=0, the pixel at stream position k lands on column NCOL-1-k. `chain_b_in` is then the enable input and `chain_a_out` the enable output. With `fill_up`=1 the roles are `chain_a_in` and `chain_b_out`.
- R5: The enable output goes low after the strobe fall that completes the row. It returns high at the next strobe fall. At all other times it is high, and the output on the input side is always high.
- R6: A device that is not yet selected ignores strobes while its enable input is high. A strobe fall seen with the enable input low selects it and is itself stored.
- R7: Once a row is full, further strobes change nothing until the next line pulse.
- R8: Column codes change only at a line-pulse falling edge or through `blank_n`/`frame_pol`. Loading data does not change them.
- R9: The column code is 1 when the frame is low and the pixel is 0, and 0 when the frame is low and the pixel is 1. With the frame high, pixel 0 gives 2 and pixel 1 gives 3.
- R10: While `blank_n`=0 every code is 0 and the line latch is held cleared, but the data latch keeps loading. After release the codes show non-select levels (1 or 2) until the next line pulse.
- R11: A line pulse falling edge restarts the count and deselects the device, even in the middle of a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dclk_in | input | 1 | Raw data strobe; data is taken on its falling edge |
| lpulse_in | input | 1 | Raw line pulse; the row transfers on its falling edge |
| nibble_mode | input | 1 | 1: four pixels per strobe, 0: eight |
| fill_up | input | 1 | 1: fill from column 0 upward, 0: from column NCOL-1 downward |
| pix_in | input | 8 | Pixel bus |
| frame_pol | input | 1 | Frame polarity for the level encoding |
| blank_n | input | 1 | Active-low blanking |
| chain_a_in | input | 1 | Chain side A input (enable input when fill_up=1) |
| chain_b_in | input | 1 | Chain side B input (enable input when fill_up=0) |
| chain_a_out | output | 1 | Chain side A output (enable output when fill_up=0) |
| chain_b_out | output | 1 | Chain side B output (enable output when fill_up=1) |
| drive_code | output | 2*NCOL | Per-column level codes; column c at bits 2c+1:2c |

## Verification
The hardest case to reach is the token hand-over. One device deselects on the same strobe fall that arms its neighbour's enable input. The neighbour must then take the next strobe and not the current one. The bench chains two reduced-width instances and streams two rows' worth of pixels across both. The enable outputs are checked after every strobe, and the column mapping of both devices is compared for each fill order and bus width. Extra strobes after both devices are full, and a row cut short by a line pulse, cover the stop and restart paths.

// File: rtl/seg_row_loader.sv
module seg_row_loader #(
  parameter int NCOL = 240
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dclk_in,
  input  logic            lpulse_in,
  input  logic            nibble_mode,
  input  logic            fill_up,
  input  logic [7:0]      pix_in,
  input  logic            frame_pol,
  input  logic            blank_n,
  input  logic            chain_a_in,
  input  logic            chain_b_in,
  output logic            chain_a_out,
  output logic            chain_b_out,
  output logic [2*NCOL-1:0] drive_code
);
  localparam int NBYTE = NCOL / 8;
  localparam int IW    = (NBYTE > 1) ? $clog2(NBYTE) : 1;

  logic [2:0] dsync, lsync;
  logic d_fall, l_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dsync <= '0;
      lsync <= '0;
    end else begin
      dsync <= {dsync[1:0], dclk_in};
      lsync <= {lsync[1:0], lpulse_in};
    end
  end

  assign d_fall = dsync[2] & ~dsync[1];
  assign l_fall = lsync[2] & ~lsync[1];

  logic          sel, done, half, eo_low;
  logic [3:0]    nib;
  logic [IW-1:0] idx;
  logic          en_in, take, byte_rdy, last;
  logic [7:0]    byte_w, byte_r;

  assign en_in    = fill_up ? chain_a_in : chain_b_in;
  assign take     = d_fall & ~l_fall & ~done & (sel | ~en_in);
  assign byte_rdy = take & (~nibble_mode | half);
  assign byte_w   = nibble_mode ? {pix_in[3:0], nib} : pix_in;
  assign last     = byte_rdy && (idx == IW'(NBYTE - 1));

  always_comb
    for (int j = 0; j < 8; j++) byte_r[j] = byte_w[7-j];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel <= 1'b0; done <= 1'b0; half <= 1'b0; eo_low <= 1'b0;
      nib <= '0;   idx <= '0;
    end else if (l_fall) begin
      sel <= 1'b0; done <= 1'b0; half <= 1'b0; eo_low <= 1'b0;
      idx <= '0;
    end else begin
      if (d_fall) eo_low <= 1'b0;
      if (take) begin
        sel <= 1'b1;
        if (nibble_mode) half <= ~half;
        if (!half) nib <= pix_in[3:0];
        if (byte_rdy) begin
          if (last) begin
            done   <= 1'b1;
            sel    <= 1'b0;
            eo_low <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end

  logic [NCOL-1:0] data_q, line_q;

  for (genvar s = 0; s < NBYTE; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        data_q[8*s +: 8] <= '0;
      else if (byte_rdy && fill_up && idx == IW'(s))
        data_q[8*s +: 8] <= byte_w;
      else if (byte_rdy && !fill_up && idx == IW'(NBYTE - 1 - s))
        data_q[8*s +: 8] <= byte_r;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       line_q <= '0;
    else if (!blank_n) line_q <= '0;
    else if (l_fall)  line_q <= data_q;
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    assign drive_code[2*c +: 2] = blank_n ? {frame_pol, ~(frame_pol ^ line_q[c])} : 2'b00;
  end

  assign chain_a_out = fill_up ? 1'b1 : ~eo_low;
  assign chain_b_out = fill_up ? ~eo_low : 1'b1;
endmodule

// File: rtl/seg_row_loader_chk.sv
module seg_row_loader_chk #(
  parameter int NCOL = 240
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fill_up,
  input logic            blank_n,
  input logic            chain_a_out,
  input logic            chain_b_out,
  input logic            d_fall,
  input logic            l_fall,
  input logic            done,
  input logic            eo_low,
  input logic            idx_zero,
  input logic [NCOL-1:0] data_q,
  input logic [NCOL-1:0] line_q
);
  a_r5_idle_side_high: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_up ? chain_a_out : chain_b_out));

  a_r5_pulse_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (eo_low && d_fall && !l_fall) |=> !eo_low);

  a_r7_full_row_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !l_fall) |=> $stable(data_q));

  a_r8_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && !l_fall) |=> $stable(line_q));

  a_r10_blank_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |=> (line_q == '0));

  a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
    l_fall |=> (idx_zero && !done && !eo_low));
endmodule

bind seg_row_loader seg_row_loader_chk #(.NCOL(NCOL)) chk_i (
  .clk(clk), .rst_n(rst_n), .fill_up(fill_up), .blank_n(blank_n),
  .chain_a_out(chain_a_out), .chain_b_out(chain_b_out),
  .d_fall(d_fall), .l_fall(l_fall), .done(done), .eo_low(eo_low),
  .idx_zero(idx == '0), .data_q(data_q), .line_q(line_q)
);

// File: tb/seg_row_loader_tb_top.sv
module seg_row_loader_tb_top;
  localparam int NCOL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dclk = 1'b0, lp = 1'b0, nib = 1'b0, up = 1'b1, frame = 1'b0, blank_n = 1'b1;
  logic [7:0] pix = '0;
  logic a_ao, a_bo, b_ao, b_bo;
  logic [2*NCOL-1:0] code_a, code_b;

  int checks = 0, fails = 0;
  bit finished = 0;
  bit vis [2][NCOL];

  always #2 clk = ~clk;

  seg_row_loader #(.NCOL(NCOL)) dut_i (
    .clk(clk), .rst_n(rst_n), .dclk_in(dclk), .lpulse_in(lp), .nibble_mode(nib),
    .fill_up(up), .pix_in(pix), .frame_pol(frame), .blank_n(blank_n),
    .chain_a_in(1'b0), .chain_b_in(1'b0), .chain_a_out(a_ao), .chain_b_out(a_bo),
    .drive_code(code_a));

  seg_row_loader #(.NCOL(NCOL)) dut_b (
    .clk(clk), .rst_n(rst_n), .dclk_in(dclk), .lpulse_in(lp), .nibble_mode(nib),
    .fill_up(up), .pix_in(pix), .frame_pol(frame), .blank_n(blank_n),
    .chain_a_in(a_bo), .chain_b_in(a_ao), .chain_a_out(b_ao), .chain_b_out(b_bo),
    .drive_code(code_b));

  function automatic bit pixv(int g, int seed);
    return ((g * 5 + seed * 3 + (g >> 2) + g * g * seed) % 3) == 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_codes(string req);
    for (int d = 0; d < 2; d++)
      for (int c = 0; c < NCOL; c++) begin
        logic [1:0] got, exp;
        got = (d == 0) ? code_a[2*c +: 2] : code_b[2*c +: 2];
        exp = !blank_n ? 2'd0 : {frame, ~(frame ^ vis[d][c])};
        chk(req, got, exp);
      end
  endtask

  task automatic strobe(logic [7:0] v);
    @(negedge clk);
    pix  = v;
    dclk = 1'b1;
    repeat (4) @(negedge clk);
    dclk = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic line_pulse();
    @(negedge clk);
    lp = 1'b1;
    repeat (4) @(negedge clk);
    lp = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic eo_check(int g);
    logic eo_a, eo_b, idle_a, idle_b;
    eo_a = up ? a_bo : a_ao;  idle_a = up ? a_ao : a_bo;
    eo_b = up ? b_bo : b_ao;  idle_b = up ? b_ao : b_bo;
    chk("R5 enable out dev0", eo_a, (g == NCOL) ? 0 : 1);
    chk("R5 enable out dev1", eo_b, (g == 2*NCOL) ? 0 : 1);
    chk("R5 idle side dev0", idle_a, 1);
    chk("R5 idle side dev1", idle_b, 1);
  endtask

  task automatic load_row(bit m4, bit dir_up, int seed, int extra);
    int w = m4 ? 4 : 8;
    int g = 0;
    nib = m4;
    up  = dir_up;
    while (g < 2*NCOL) begin
      logic [7:0] v;
      v = m4 ? 8'hF0 : 8'h00;
      for (int j = 0; j < w; j++) v[j] = pixv(g + j, seed);
      strobe(v);
      g += w;
      eo_check(g);
    end
    for (int e = 0; e < extra; e++) begin
      strobe(8'hFF);
      eo_check(-1);
    end
  endtask

  task automatic model_row(bit dir_up, int seed);
    for (int d = 0; d < 2; d++)
      for (int c = 0; c < NCOL; c++) begin
        int k = dir_up ? c : NCOL - 1 - c;
        vis[d][c] = pixv(d*NCOL + k, seed);
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    for (int d = 0; d < 2; d++) for (int c = 0; c < NCOL; c++) vis[d][c] = 0;
    check_codes("R1 reset codes");
    chk("R1 chain a out", a_ao, 1);
    chk("R1 chain b out", a_bo, 1);

    // R2 R6 byte mode, fill upward, cascade hand-over
    load_row(0, 1, 1, 0);
    check_codes("R8 codes unchanged before line pulse");
    line_pulse();
    model_row(1, 1);
    check_codes("R2 R6 byte mode upward");
    frame = 1'b1;
    @(negedge clk);
    check_codes("R9 frame high encoding");
    frame = 1'b0;
    @(negedge clk);
    check_codes("R9 frame low encoding");

    // R3 R7 nibble mode upward with surplus strobes
    load_row(1, 1, 2, 3);
    line_pulse();
    model_row(1, 2);
    check_codes("R3 R7 nibble mode upward");

    // R4 R7 byte mode downward
    load_row(0, 0, 3, 2);
    line_pulse();
    model_row(0, 3);
    check_codes("R4 byte mode downward");

    // R3 R4 nibble mode downward
    frame = 1'b1;
    load_row(1, 0, 4, 0);
    line_pulse();
    model_row(0, 4);
    check_codes("R3 R4 nibble mode downward");
    frame = 1'b0;

    // R11 partial row then restart
    nib = 1'b0; up = 1'b1;
    strobe(8'hA5);
    line_pulse();
    load_row(0, 1, 6, 0);
    line_pulse();
    model_row(1, 6);
    check_codes("R11 restart after partial row");

    // R10 blanking
    blank_n = 1'b0;
    repeat (2) @(negedge clk);
    check_codes("R10 blank forces level 0");
    load_row(1, 1, 7, 0);
    line_pulse();
    check_codes("R10 blank holds through line pulse");
    blank_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int d = 0; d < 2; d++) for (int c = 0; c < NCOL; c++) vis[d][c] = 0;
    check_codes("R10 non-select after release");
    frame = 1'b1;
    @(negedge clk);
    check_codes("R10 R9 non-select frame high");
    line_pulse();
    model_row(1, 7);
    check_codes("R10 data latch loaded during blank");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule